// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block computes memory addresses for a data path that walks several buffers at once. It holds four pointer slots. Each slot has its own index, base and length register, and four modifier registers are shared by all slots. Every request names a pointer slot and where its modifier comes from: either one of the modifier registers or an 8-bit signed immediate carried in the request. The request also chooses pre-modify or post-modify addressing, whether the index register is updated, and whether the update is circular or bit-reversed.

In circular addressing the updated index is wrapped so that it stays inside the window that starts at the base and spans the length. A length of zero turns the wrap off, and the arithmetic is then plain two's-complement. In bit-reversed addressing the update uses reverse-carry addition, where carries run from the most significant bit toward the least. Stepping by half the transform size therefore visits FFT samples in bit-reversed order.

Requests enter through a valid/ready port and results leave through a registered valid/ready port. A request is accepted when the output stage is empty or is being drained in the same cycle. While the output is stalled it holds its values and the block refuses new requests. The configuration write port is a plain strobe that is always accepted.

Top module: `cbuf_agu`

## Requirements
- R1: After reset all index, base, length and modifier registers are zero, `res_valid` is 0 and `req_ready` is 1.
- R2: When `cfg_we` is 1, `cfg_wdata` is written at the next clock edge into the register that `cfg_slot` picks, of the kind that `cfg_kind` picks: 0 selects index, 1 base, 2 length and 3 modifier.
- R3: On a post-modify request (`req_pre`=0) with `req_wb`=1, `res_addr` is the old index, `res_index` is the modified value, and the index register takes the modified value.
- R4: On a post-modify request with `req_wb`=0, `res_index` still shows the modified value, but the index register keeps its old value.
- R5: On a pre-modify request (`req_pre`=1), `res_addr` and `res_index` are both the modified value, and the index register is never changed, whatever `req_wb` is.
- R6: When `req_use_imm`=1 the modifier is `req_imm` sign-extended from 8 bits. Otherwise it is the modifier register numbered `req_msel`.
- R7: In circular mode (`req_brev`=0) with a nonzero length L, the modified value is base + ((index − base + modifier) mod L). This holds for an index inside the window and for |modifier| ≤ L, including a wrap past the top of the window.
- R8: In circular mode a negative modifier that takes the value below the base wraps it to the top of the window.
- R9: With length zero, circular mode gives index + modifier modulo 2^AW, with no wrap.
- R10: With `req_brev`=1 the modified value is the reverse-carry sum of index and modifier over all AW bits; base and length are ignored. Starting from index 0 with modifier 4, successive post-modify updates visit 4, 2, 6, 1, 5, 3, 7, 0.
- R11: An accepted request shows its results with `res_valid`=1 on the clock edge that follows acceptance.
- R12: `req_ready` = !`res_valid` || `res_ready`. While `res_valid`=1 and `res_ready`=0, `res_addr`, `res_index` and `res_valid` stay unchanged and no request is accepted.
- R13: When an index configuration write and a write-back target the same slot in the same cycle, the configuration value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Register kind: 0 index, 1 base, 2 length, 3 modifier |
| cfg_slot | input | 2 | Slot number for the configuration write |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_ptr | input | 2 | Pointer slot used by the request |
| req_use_imm | input | 1 | 1: immediate modifier, 0: modifier register |
| req_imm | input | 8 | Signed immediate modifier |
| req_msel | input | 2 | Modifier register number |
| req_pre | input | 1 | 1: pre-modify, 0: post-modify |
| req_wb | input | 1 | Write back the modified index (post-modify only) |
| req_brev | input | 1 | 1: bit-reversed update, 0: circular/linear update |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_addr | output | 16 | Memory address |
| res_index | output | 16 | Modified index value |

## Verification
Post-modify steps inside a window check that the address lags the index by one step, and they tell write-back apart from no write-back. Immediate steps that cross the top of the window and the bottom of it check the wrap in both directions. A zero-length slot with a large negative immediate shows sign extension without any wrap. An eight-step reverse-carry walk checks the bit-reversed order. A stalled output with a held request separates correct back-pressure from a dropped or double-counted request. A configuration write in the same cycle as a write-back to the same slot shows which of the two wins.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    KIND_INDEX = 2'd0,
    KIND_BASE  = 2'd1,
    KIND_LEN   = 2'd2,
    KIND_MOD   = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile
  import agu_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NPTR  = 4,
  localparam int PW   = $clog2(NPTR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  cfg_kind_e                cfg_kind,
  input  logic [PW-1:0]            cfg_slot,
  input  logic [AW-1:0]            cfg_wdata,
  input  logic                     wb_en,
  input  logic [PW-1:0]            wb_slot,
  input  logic [AW-1:0]            wb_data,
  output logic [NPTR-1:0][AW-1:0]  idx_q,
  output logic [NPTR-1:0][AW-1:0]  base_q,
  output logic [NPTR-1:0][AW-1:0]  len_q,
  output logic [NPTR-1:0][AW-1:0]  mod_q
);

  for (genvar g = 0; g < NPTR; g++) begin : g_slot
    logic hit;
    assign hit = cfg_we && (cfg_slot == PW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        idx_q[g]  <= '0;
        base_q[g] <= '0;
        len_q[g]  <= '0;
        mod_q[g]  <= '0;
      end else begin
        if (hit && cfg_kind == KIND_INDEX)   idx_q[g] <= cfg_wdata;
        else if (wb_en && wb_slot == PW'(g)) idx_q[g] <= wb_data;
        if (hit && cfg_kind == KIND_BASE)    base_q[g] <= cfg_wdata;
        if (hit && cfg_kind == KIND_LEN)     len_q[g]  <= cfg_wdata;
        if (hit && cfg_kind == KIND_MOD)     mod_q[g]  <= cfg_wdata;
      end
    end
  end

  // R13: configuration write to an index wins over a write-back in the same cycle
  p_cfg_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == KIND_INDEX && wb_en && wb_slot == cfg_slot)
    |=> idx_q[$past(cfg_slot)] == $past(cfg_wdata));

endmodule

// File: rtl/agu_modify.sv
module agu_modify #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] modv,
  input  logic          brev,
  output logic [AW-1:0] res
);

  localparam int XW = AW + 2;

  function automatic logic [AW-1:0] bitrev(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  logic [AW-1:0]        rc_sum;
  logic [AW-1:0]        off;
  logic signed [XW-1:0] s_raw;
  logic signed [XW-1:0] s_wrap;
  logic signed [XW-1:0] lenx;
  logic [AW-1:0]        circ;

  always_comb begin
    rc_sum = bitrev(bitrev(idx) + bitrev(modv));

    off    = idx - base;
    lenx   = XW'({2'b00, len});
    s_raw  = $signed({2'b00, off}) + $signed({{2{modv[AW-1]}}, modv});
    if (s_raw < 0)          s_wrap = s_raw + lenx;
    else if (s_raw >= lenx) s_wrap = s_raw - lenx;
    else                    s_wrap = s_raw;

    if (len == '0) circ = idx + modv;
    else           circ = base + s_wrap[AW-1:0];

    res = brev ? rc_sum : circ;
  end

endmodule

// File: rtl/cbuf_agu.sv
module cbuf_agu
  import agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NPTR = 4,
  parameter int IMMW = 8,
  localparam int PW  = $clog2(NPTR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_kind,
  input  logic [PW-1:0]   cfg_slot,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PW-1:0]   req_ptr,
  input  logic            req_use_imm,
  input  logic [IMMW-1:0] req_imm,
  input  logic [PW-1:0]   req_msel,
  input  logic            req_pre,
  input  logic            req_wb,
  input  logic            req_brev,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [AW-1:0]   res_addr,
  output logic [AW-1:0]   res_index
);

  logic [NPTR-1:0][AW-1:0] idx_q, base_q, len_q, mod_q;
  logic                    accept, wb_en;
  logic [AW-1:0]           cur_idx, cur_base, cur_len, modv, new_idx;

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;
  assign wb_en     = accept && !req_pre && req_wb;

  assign cur_idx  = idx_q[req_ptr];
  assign cur_base = base_q[req_ptr];
  assign cur_len  = len_q[req_ptr];
  assign modv     = req_use_imm ? AW'($signed(req_imm)) : mod_q[req_msel];

  agu_regfile #(.AW(AW), .NPTR(NPTR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_kind  (cfg_kind_e'(cfg_kind)),
    .cfg_slot  (cfg_slot),
    .cfg_wdata (cfg_wdata),
    .wb_en     (wb_en),
    .wb_slot   (req_ptr),
    .wb_data   (new_idx),
    .idx_q     (idx_q),
    .base_q    (base_q),
    .len_q     (len_q),
    .mod_q     (mod_q)
  );

  agu_modify #(.AW(AW)) u_mod (
    .idx  (cur_idx),
    .base (cur_base),
    .len  (cur_len),
    .modv (modv),
    .brev (req_brev),
    .res  (new_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_index <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_addr  <= req_pre ? new_idx : cur_idx;
      res_index <= new_idx;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R11: accepted request is visible on the next edge
  p_accept_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  // R12: stalled output holds still
  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_index)));

  // R5: pre-modify leaves the index register alone
  p_pre_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_pre && !(cfg_we && cfg_kind == 2'd0 && cfg_slot == req_ptr))
    |=> idx_q[$past(req_ptr)] == $past(cur_idx));

  // R7: circular result stays inside the window
  p_circ_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_brev && cur_len != '0 && (cur_idx - cur_base) < cur_len
     && ($signed(modv) <= $signed({1'b0, cur_len}))
     && ($signed(modv) >= -$signed({1'b0, cur_len})))
    |=> (res_index - $past(cur_base)) < $past(cur_len));

endmodule

// File: tb/cbuf_agu_tb.sv
module cbuf_agu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [1:0]  cfg_slot = '0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_ptr = '0;
  logic        req_use_imm = 1'b0;
  logic [7:0]  req_imm = '0;
  logic [1:0]  req_msel = '0;
  logic        req_pre = 1'b0;
  logic        req_wb = 1'b0;
  logic        req_brev = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_addr;
  logic [15:0] res_index;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbuf_agu u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_slot(cfg_slot), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_ptr(req_ptr), .req_use_imm(req_use_imm),
    .req_imm(req_imm), .req_msel(req_msel), .req_pre(req_pre),
    .req_wb(req_wb), .req_brev(req_brev), .res_valid(res_valid),
    .res_ready(res_ready), .res_addr(res_addr), .res_index(res_index)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] kind, input logic [1:0] slot, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_slot = slot; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_req(input logic [1:0] ptr, input logic use_imm, input logic [7:0] imm,
                         input logic [1:0] msel, input logic pre, input logic wb, input logic brev);
    req_ptr = ptr; req_use_imm = use_imm; req_imm = imm; req_msel = msel;
    req_pre = pre; req_wb = wb; req_brev = brev;
  endtask

  // one request, results sampled at the following negedge
  task automatic issue(input logic [1:0] ptr, input logic use_imm, input logic [7:0] imm,
                       input logic [1:0] msel, input logic pre, input logic wb, input logic brev);
    @(negedge clk);
    set_req(ptr, use_imm, imm, msel, pre, wb, brev);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // zero-step read of an index through the request port
  task automatic peek(input logic [1:0] ptr, input string req, input logic [15:0] exp);
    issue(ptr, 1'b1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0);
    check(req, "index readback", {16'h0, res_addr}, {16'h0, exp});
  endtask

  task automatic t_reset;
    check("R1", "res_valid", {31'h0, res_valid}, 32'h0);
    check("R1", "req_ready", {31'h0, req_ready}, 32'h1);
    issue(2'd0, 1'b0, 8'h00, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R1", "addr zero", {16'h0, res_addr}, 32'h0);
    check("R11", "res_valid after accept", {31'h0, res_valid}, 32'h1);
  endtask

  task automatic t_post;
    cfg(2'd0, 2'd0, 16'h0100);
    cfg(2'd1, 2'd0, 16'h0100);
    cfg(2'd2, 2'd0, 16'h0010);
    cfg(2'd3, 2'd0, 16'h0003);
    issue(2'd0, 1'b0, 8'h00, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R3", "addr old index", {16'h0, res_addr}, 32'h0100);
    check("R6", "register modifier", {16'h0, res_index}, 32'h0103);
    issue(2'd0, 1'b1, 8'h05, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R2", "written-back index", {16'h0, res_addr}, 32'h0103);
    check("R6", "immediate modifier", {16'h0, res_index}, 32'h0108);
  endtask

  task automatic t_wrap;
    issue(2'd0, 1'b1, 8'h0A, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R7", "wrap over top", {16'h0, res_index}, 32'h0102);
    issue(2'd0, 1'b1, 8'hFC, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R8", "addr before wrap", {16'h0, res_addr}, 32'h0102);
    check("R8", "wrap below base", {16'h0, res_index}, 32'h010E);
  endtask

  task automatic t_nowb;
    issue(2'd0, 1'b1, 8'h01, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R4", "modified shown", {16'h0, res_index}, 32'h010F);
    peek(2'd0, "R4", 16'h010E);
  endtask

  task automatic t_pre;
    issue(2'd0, 1'b1, 8'h02, 2'd0, 1'b1, 1'b1, 1'b0);
    check("R5", "pre addr", {16'h0, res_addr}, 32'h0100);
    check("R5", "pre index", {16'h0, res_index}, 32'h0100);
    peek(2'd0, "R5", 16'h010E);
  endtask

  task automatic t_linear;
    cfg(2'd0, 2'd1, 16'h0020);
    issue(2'd1, 1'b1, 8'h80, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R9", "linear negative", {16'h0, res_index}, 32'hFFA0);
    peek(2'd1, "R9", 16'hFFA0);
  endtask

  task automatic t_brev;
    logic [15:0] seq [8] = '{16'd4, 16'd2, 16'd6, 16'd1, 16'd5, 16'd3, 16'd7, 16'd0};
    logic [15:0] prev = 16'd0;
    cfg(2'd3, 2'd2, 16'd4);
    cfg(2'd1, 2'd2, 16'h0300);
    cfg(2'd2, 2'd2, 16'd3);
    for (int i = 0; i < 8; i++) begin
      issue(2'd2, 1'b0, 8'h00, 2'd2, 1'b0, 1'b1, 1'b1);
      check("R10", "brev addr", {16'h0, res_addr}, {16'h0, prev});
      check("R10", "brev index", {16'h0, res_index}, {16'h0, seq[i]});
      prev = seq[i];
    end
  endtask

  task automatic t_stall;
    cfg(2'd0, 2'd3, 16'h0040);
    @(negedge clk);
    res_ready = 1'b0;
    set_req(2'd3, 1'b1, 8'h01, 2'd0, 1'b0, 1'b1, 1'b0);
    req_valid = 1'b1;
    @(negedge clk);
    check("R11", "valid after accept", {31'h0, res_valid}, 32'h1);
    check("R12", "ready low in stall", {31'h0, req_ready}, 32'h0);
    check("R12", "first addr", {16'h0, res_addr}, 32'h0040);
    @(negedge clk);
    check("R12", "held addr", {16'h0, res_addr}, 32'h0040);
    check("R12", "held index", {16'h0, res_index}, 32'h0041);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12", "second addr", {16'h0, res_addr}, 32'h0041);
    check("R12", "second index", {16'h0, res_index}, 32'h0042);
    @(negedge clk);
    check("R12", "drained", {31'h0, res_valid}, 32'h0);
  endtask

  task automatic t_priority;
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 2'd0; cfg_slot = 2'd0; cfg_wdata = 16'h0105;
    set_req(2'd0, 1'b1, 8'h01, 2'd0, 1'b0, 1'b1, 1'b0);
    req_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R13", "addr same cycle", {16'h0, res_addr}, 32'h010E);
    peek(2'd0, "R13", 16'h0105);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_post();
    t_wrap();
    t_nowb();
    t_pre();
    t_linear();
    t_brev();
    t_stall();
    t_priority();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule